// File: doc/BRIEF.md
# JTAG Test Clock Generator with Return-Clock Mode

This block makes the JTAG test clock (TCK) for a debug probe from a fast system clock (60 MHz in the intended use). A shift engine holds a tick request high for as long as it wants TCK cycles. The block answers each level change of TCK with a one-cycle pulse, so the engine knows when to drive TDI/TMS and when to sample TDO. The first edge of every TCK cycle is a rising edge, and TCK rests low while idle.

There are two pacing modes. In divided mode a programmable divisor sets the period: each half-period lasts half the divisor in system-clock cycles, so TCK runs at the reference frequency divided by the divisor with an exact 50 % duty cycle. Legal divisors are the even values from 2 to 8190. In return-clock mode the target echoes TCK back. The echo passes through a two-flop synchroniser, and each TCK level is held until the synchronised echo matches it. If the echo does not arrive within a fixed number of reference cycles, the block forces the edge anyway and raises a sticky error flag. Software clears that flag with a strobe, which it is expected to do right after driving the test reset, since that reset silences the target's echo.

The divisor and the mode are captured only when a burst starts from idle. Changes made while TCK is running wait for the next idle period.

Top module: `jtck_gen`

## Requirements
- R1: After reset, tck_o, rise_o, fall_o and err_o are all 0.
- R2: While tick_req_i stays low and the block is idle, tck_o stays low and neither rise_o nor fall_o pulses.
- R3: In divided mode (adapt_i = 0) with an even divisor D, every high level and every low level of TCK lasts exactly D/2 clk cycles while the request is held, for D from 2 to 8190.
- R4: An odd divisor is rounded up to the next even value before halving (7 gives 4-cycle half-periods), and divisors 0 and 1 behave as 2.
- R5: rise_o is 1 in exactly the cycle in which tck_o is first high, and fall_o in exactly the cycle in which tck_o is first low; at no other time does either pulse.
- R6: div_i and adapt_i are sampled only on the cycle a burst leaves idle. Changing either during a burst does not alter that burst's timing, and a new divisor applies to the next burst.
- R7: In return-clock mode (adapt_i = 1), each TCK level is held until the two-flop-synchronised ret_clk_i equals it. For an echo that follows TCK by d clk cycles, each level lasts 3 + d cycles.
- R8: In return-clock mode, if no match arrives within TIMEOUT_CYC cycles of a TCK edge, the next edge is forced exactly TIMEOUT_CYC cycles after it and err_o is set. An echo that arrives in time never sets err_o.
- R9: err_o stays set until a cycle with err_clr_i high and then reads 0 from the next cycle. A new timeout in the same cycle as the clear takes priority.
- R10: When tick_req_i drops, the current TCK cycle finishes its high and low levels, and then tck_o rests low.
- R11: From idle, a cycle with tick_req_i high makes tck_o and rise_o high from the next clk cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | TCK divisor; even values 2..8190 are legal |
| adapt_i | input | 1 | 1 selects return-clock pacing, 0 selects divided pacing |
| err_clr_i | input | 1 | Clear strobe for the sticky timeout flag |
| ret_clk_i | input | 1 | Return clock echoed by the target, asynchronous |
| tick_req_i | input | 1 | Request from the shift engine to keep TCK running |
| tck_o | output | 1 | JTAG test clock |
| rise_o | output | 1 | One-cycle pulse on the first high cycle of TCK |
| fall_o | output | 1 | One-cycle pulse on the first low cycle of TCK |
| err_o | output | 1 | Sticky return-clock timeout flag |

## Verification
The embedded properties assume that the shift engine holds tick_req_i steady between reference edges, and that the echo is either absent or follows TCK with a bounded delay shorter than the timeout. The stimulus keeps within this. It changes every input just after the falling reference edge. It models the target echo as TCK delayed by 0 to 5 cycles, or switches the echo off entirely to provoke timeouts. Divisors are drawn at random, both odd and even, from a small range so that many bursts fit in the run, and directed cases cover the extremes, the odd and below-minimum values, and changes made in the middle of a burst.

// File: rtl/jtck_pkg.sv
package jtck_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

endpackage

// File: rtl/jtck_sync.sv
module jtck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/jtck_half.sv
module jtck_half #(
  parameter int DIV_W = 13
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] half_o
);

  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(1);

  logic below_min;

  always_comb begin
    below_min = (div_i < DIV_W'(2));
    if (below_min) begin
      half_o = MIN_HALF;
    end else begin
      // round an odd divisor up, then halve
      half_o = (div_i >> 1) + DIV_W'(div_i[0]);
    end
  end

endmodule

// File: rtl/jtck_errflag.sv
module jtck_errflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);

  logic err_q;
  logic err_d;

  always_comb begin
    err_d = err_q;
    if (set_i) begin
      err_d = 1'b1;
    end else if (clr_i) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign err_o = err_q;

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clr_i |=> err_q);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> err_q);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !err_q);

endmodule

// File: rtl/jtck_seq.sv
module jtck_seq
  import jtck_pkg::*;
#(
  parameter int DIV_W       = 13,
  parameter int TIMEOUT_CYC = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             adapt_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             ret_s_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             tmo_o
);

  localparam int TW = $clog2(TIMEOUT_CYC);
  localparam int CW = (TW > DIV_W) ? TW : DIV_W;
  localparam logic [CW-1:0] TMO_LAST = CW'(TIMEOUT_CYC - 1);

  phase_e           state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [DIV_W-1:0] half_q, half_d;
  logic             adapt_q, adapt_d;
  logic             tck_q, tck_d;
  logic             rise_q, rise_d;
  logic             fall_q, fall_d;

  logic             match;
  logic             tmo_hit;
  logic             phase_end;
  logic             forced;
  logic [CW-1:0]    cnt_step;
  logic [CW-1:0]    cnt_reload;
  logic [CW-1:0]    cnt_start;

  always_comb begin
    match      = (ret_s_i == tck_q);
    tmo_hit    = (cnt_q == TMO_LAST);
    phase_end  = adapt_q ? (match || tmo_hit) : (cnt_q == '0);
    forced     = adapt_q && !match && tmo_hit;
    cnt_step   = adapt_q ? (cnt_q + CW'(1)) : (cnt_q - CW'(1));
    cnt_reload = adapt_q ? '0 : (CW'(half_q) - CW'(1));
    cnt_start  = adapt_i ? '0 : (CW'(half_i) - CW'(1));
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    adapt_d = adapt_q;
    tck_d   = tck_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    tmo_o   = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (req_i) begin
          state_d = PH_HIGH;
          half_d  = half_i;
          adapt_d = adapt_i;
          cnt_d   = cnt_start;
          tck_d   = 1'b1;
          rise_d  = 1'b1;
        end
      end
      PH_HIGH: begin
        if (phase_end) begin
          state_d = PH_LOW;
          cnt_d   = cnt_reload;
          tck_d   = 1'b0;
          fall_d  = 1'b1;
          tmo_o   = forced;
        end else begin
          cnt_d = cnt_step;
        end
      end
      PH_LOW: begin
        if (phase_end) begin
          tmo_o = forced;
          if (req_i) begin
            state_d = PH_HIGH;
            cnt_d   = cnt_reload;
            tck_d   = 1'b1;
            rise_d  = 1'b1;
          end else begin
            state_d = PH_IDLE;
            cnt_d   = '0;
          end
        end else begin
          cnt_d = cnt_step;
        end
      end
      default: begin
        state_d = PH_IDLE;
        cnt_d   = '0;
        tck_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      half_q  <= '0;
      adapt_q <= 1'b0;
      tck_q   <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      adapt_q <= adapt_d;
      tck_q   <= tck_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign tck_o  = tck_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_IDLE) |-> !tck_q);

  a_r5_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_q && fall_q));

  a_r5_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> tck_q && !$past(tck_q));

  a_r5_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> !tck_q && $past(tck_q));

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !adapt_q && (state_q != PH_IDLE) |-> (cnt_q < CW'(half_q)));

  a_r4_half_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE) |-> (half_q != '0));

  a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE) && ($past(state_q) != PH_IDLE)
      |-> $stable(half_q) && $stable(adapt_q));

  a_r7_wait_echo: assert property (@(posedge clk) disable iff (!rst_n)
    adapt_q && (state_q != PH_IDLE) && (ret_s_i != tck_q) && (cnt_q != TMO_LAST)
      |=> $stable(tck_q));

  a_r8_tmo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    adapt_q && (state_q != PH_IDLE) |-> (cnt_q <= TMO_LAST));

endmodule

// File: rtl/jtck_gen.sv
module jtck_gen #(
  parameter int DIV_W       = 13,
  parameter int TIMEOUT_CYC = 65536,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             adapt_i,
  input  logic             err_clr_i,
  input  logic             ret_clk_i,
  input  logic             tick_req_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             err_o
);

  logic             ret_s;
  logic [DIV_W-1:0] half_w;
  logic             tmo_w;

  jtck_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ret_clk_i),
    .sync_o  (ret_s)
  );

  jtck_half #(
    .DIV_W (DIV_W)
  ) u_half (
    .div_i  (div_i),
    .half_o (half_w)
  );

  jtck_seq #(
    .DIV_W       (DIV_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (tick_req_i),
    .adapt_i (adapt_i),
    .half_i  (half_w),
    .ret_s_i (ret_s),
    .tck_o   (tck_o),
    .rise_o  (rise_o),
    .fall_o  (fall_o),
    .tmo_o   (tmo_w)
  );

  jtck_errflag u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (tmo_w),
    .clr_i (err_clr_i),
    .err_o (err_o)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !tck_o);

endmodule

// File: tb/jtck_gen_test.sv
`timescale 1ns/1ps
module jtck_gen_test;

  localparam int DW  = 13;
  localparam int TMO = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] div_i;
  logic          adapt_i, err_clr_i, ret_clk_i, tick_req_i;
  logic          tck_o, rise_o, fall_o, err_o;

  always #2.5 clk = ~clk;

  jtck_gen #(.DIV_W(DW), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .adapt_i(adapt_i),
    .err_clr_i(err_clr_i), .ret_clk_i(ret_clk_i), .tick_req_i(tick_req_i),
    .tck_o(tck_o), .rise_o(rise_o), .fall_o(fall_o), .err_o(err_o)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc = 0;
  int    exp_hi, exp_lo;
  string tag_hi, tag_lo;
  int    nrise = 0;
  int    t_rise = 0, t_fall = 0;
  bit    hi_valid = 0, lo_valid = 0;
  bit    prev_tck = 0;
  int    stray = 0;
  logic [7:0] hist = '0;
  bit    echo_en = 0;
  int    echo_d = 0;
  bit    done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int half_of(input int d);
    if (d < 2) return 1;
    return (d + 1) / 2;
  endfunction

  // target echo model and edge monitor
  always @(negedge clk) begin
    cyc++;
    hist = {hist[6:0], tck_o};
    ret_clk_i = echo_en ? hist[echo_d] : 1'b0;
    if (rst_n) begin
      if (tck_o && !prev_tck) begin
        chk(rise_o === 1'b1, "R5 rise pulse", int'(rise_o), 1);
        if (lo_valid) chk(cyc - t_fall == exp_lo, tag_lo, cyc - t_fall, exp_lo);
        t_rise = cyc; hi_valid = 1; nrise++;
      end else if (!tck_o && prev_tck) begin
        chk(fall_o === 1'b1, "R5 fall pulse", int'(fall_o), 1);
        if (hi_valid) chk(cyc - t_rise == exp_hi, tag_hi, cyc - t_rise, exp_hi);
        t_fall = cyc; lo_valid = 1;
      end else if (rise_o || fall_o) begin
        stray++;
      end
    end
    prev_tck = tck_o;
  end

  task automatic set_div(input int d, input string tag);
    div_i  = DW'(d);
    exp_hi = half_of(d);
    exp_lo = exp_hi;
    tag_hi = {tag, " high length"};
    tag_lo = {tag, " low length"};
  endtask

  task automatic set_echo(input int d);
    echo_en = 1; echo_d = d;
    exp_hi = 3 + d; exp_lo = 3 + d;
    tag_hi = "R7 echo high length";
    tag_lo = "R7 echo low length";
  endtask

  task automatic run_burst(input int n, input int new_div, input bit flip_mode);
    @(negedge clk);
    lo_valid = 0; hi_valid = 0; nrise = 0;
    tick_req_i = 1'b1;
    @(negedge clk);
    chk(tck_o === 1'b1 && rise_o === 1'b1, "R11 start latency", int'(tck_o), 1);
    if (new_div >= 0) div_i = DW'(new_div);
    if (flip_mode) adapt_i = ~adapt_i;
    while (nrise < n) @(negedge clk);
    tick_req_i = 1'b0;
    repeat (exp_hi + exp_lo + 6) @(negedge clk);
    chk(tck_o === 1'b0, "R10 rests low after drop", int'(tck_o), 0);
  endtask

  initial begin
    int unused;
    bit quiet;
    unused = $urandom(32'd20240611);
    div_i = DW'(6); adapt_i = 0; err_clr_i = 0; tick_req_i = 0;
    ret_clk_i = 0; exp_hi = 3; exp_lo = 3;
    tag_hi = "R3"; tag_lo = "R3";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tck_o === 1'b0, "R1 tck after reset", int'(tck_o), 0);
    chk(rise_o === 1'b0 && fall_o === 1'b0, "R1 pulses after reset", int'(rise_o | fall_o), 0);
    chk(err_o === 1'b0, "R1 err after reset", int'(err_o), 0);

    quiet = 1;
    repeat (20) begin
      @(negedge clk);
      if (tck_o || rise_o || fall_o) quiet = 0;
    end
    chk(quiet, "R2 idle without request", int'(quiet), 1);

    set_div(2, "R3 div 2");       run_burst(4, -1, 0);
    set_div(8190, "R3 div 8190"); run_burst(2, -1, 0);
    set_div(7, "R4 div 7");       run_burst(3, -1, 0);
    set_div(1, "R4 div 1");       run_burst(3, -1, 0);
    set_div(0, "R4 div 0");       run_burst(3, -1, 0);

    for (int i = 0; i < 10; i++) begin
      int d;
      d = int'($urandom_range(2, 40));
      set_div(d, (d % 2 == 1) ? "R4 random odd" : "R3 random even");
      run_burst(int'($urandom_range(2, 5)), -1, 0);
    end

    // R6: mid-burst divisor change ignored, applied next burst
    set_div(6, "R6 divisor held in burst");
    run_burst(4, 20, 0);
    set_div(20, "R6 new divisor next burst");
    run_burst(2, -1, 0);
    // R6: mid-burst mode flip ignored (no echo, would time out)
    echo_en = 0;
    set_div(4, "R6 mode held in burst");
    run_burst(3, -1, 1);
    adapt_i = 0;

    // R7: return-clock pacing
    adapt_i = 1;
    set_echo(0); run_burst(3, -1, 0);
    for (int i = 0; i < 6; i++) begin
      set_echo(int'($urandom_range(0, 5)));
      run_burst(int'($urandom_range(2, 4)), -1, 0);
    end
    chk(err_o === 1'b0, "R8 no timeout with timely echo", int'(err_o), 0);

    // R8: timeout with no echo
    echo_en = 0;
    exp_hi = TMO; exp_lo = 1;
    tag_hi = "R8 forced high length"; tag_lo = "R8 low length without echo";
    run_burst(2, -1, 0);
    chk(err_o === 1'b1, "R8 timeout sets flag", int'(err_o), 1);

    // R9: sticky, then clear
    set_echo(1); run_burst(2, -1, 0);
    chk(err_o === 1'b1, "R9 flag sticky", int'(err_o), 1);
    @(negedge clk); err_clr_i = 1'b1;
    @(negedge clk); err_clr_i = 1'b0;
    chk(err_o === 1'b0, "R9 clear strobe", int'(err_o), 0);
    adapt_i = 0;

    chk(stray == 0, "R5 no stray pulses", stray, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule